// File: doc/BRIEF.md
# Symmetric PWM Up/Down Timer

This block is an up/down timer that produces a PWM waveform centred on the middle of each period. An 8-bit counter climbs from zero to a ceiling value and then falls back to zero. One compare output is cleared or set when the counter meets a compare value. The polarity depends on the direction of travel, so each pulse sits symmetrically around the bottom of the count. A prescaler sets the counting rate: the counter moves only on enable pulses taken from a free-running divider, with a divide-by factor of 1, 8, 32, 64, 128, 256 or 1024.

The ceiling is either the full-scale value or the value in compare register A, chosen by a mode field. The output is compared against compare register B. Both compare registers are double-buffered: a write goes into a holding register and becomes active only when the counter turns at its ceiling. Software therefore never sees a torn period. The compare output reaches the pin only when the pin's direction bit enables it. A sticky overflow flag marks each pass through the bottom of the count.

Top module: `pcpwm_timer`

## Requirements
- R1: While reset is asserted, the counter reads 0, the overflow flag is 0, the compare output register is low, and the count direction is up.
- R2: The divider select takes these encodings: 0 stops the counter, and 1 to 7 give divide factors 1, 8, 32, 64, 128, 256 and 1024. A free-running divider that reset clears issues an enable in every clock where its low log2(N) bits are zero. The counter moves once per enable.
- R3: Each enable moves the counter one step. Counting up, it increments until it is at or above the ceiling, then decrements and turns down. Counting down, it decrements to 0, then steps to 1 and turns up. One period therefore lasts 2 x ceiling enables, which is 510 x N clocks for the full-scale ceiling.
- R4: Waveform mode 3 fixes the ceiling at 255, and mode 7 uses the active compare-A value. Any other mode value holds the counter. A ceiling of 0 holds the counter at 0.
- R5: In output mode 2 (non-inverted), the output register goes low on an enable where the counter equals the active compare-B value while counting up, and high on one where it is equal while counting down.
- R6: In output mode 3 (inverted), every level in R5, R7 and R8 is replaced by its complement. In output modes 0 and 1, the output register holds its value.
- R7: A compare-B value of 0 keeps the non-inverted output low. A value at or above the ceiling keeps it high from the first ceiling turn onward. For a ceiling of 255 and compare 100, the output is high for 200 of every 510 clocks at N=1.
- R8: On the enable that turns the counter down at the ceiling, the output is forced to the up-match level. This happens even when no match occurred on the way up. The exception is a newly loaded compare value that is nonzero and not below the ceiling, in which case the down-match level is forced. When the counter passes through 0 while counting down, the output takes the down-match level, or the up-match level if the compare value is 0.
- R9: Writes to compare A or B change only a holding register. The active value takes the held value on the enable that turns the counter at the ceiling.
- R10: The output-enable is high exactly when the direction bit is 1 and the output mode is 2 or 3. When it is low, the pin reads 0.
- R11: The overflow flag sets on the enable where the counter turns up at 0. It stays set until a one-cycle clear pulse, and a set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_sel | input | 3 | Divider select (0 stops) |
| wave_mode | input | 3 | Waveform mode: 3 full-scale ceiling, 7 ceiling from compare A |
| com_mode | input | 2 | Output mode: 2 non-inverted, 3 inverted, 0/1 output held |
| dir_en | input | 1 | Pin direction bit; 1 lets the compare output drive the pin |
| cmpa_wdata | input | W | Compare A write data |
| cmpa_we | input | 1 | Compare A write strobe |
| cmpb_wdata | input | W | Compare B write data |
| cmpb_we | input | 1 | Compare B write strobe |
| ovf_clr | input | 1 | Overflow flag clear pulse |
| count_o | output | W | Current counter value |
| oc_pin | output | 1 | Gated compare output pin |
| oc_oe | output | 1 | Pin output enable |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with its defaults: an 8-bit counter, a 10-bit divider and buffered compare registers. At these values a full-scale period at N=1 takes 510 clocks, so duty-cycle windows, both extreme compare values and a forced ceiling transition all fit in a short run. The largest divider, 1024, is reached by pairing it with a ceiling of 2 taken from compare A. A lockstep model checks the counter, pin, enable and flag in every cycle across all of these phases.

// File: rtl/pcpwm_pkg.sv
package pcpwm_pkg;

   typedef enum logic [1:0] {
      OUT_HOLD0  = 2'd0,
      OUT_HOLD1  = 2'd1,
      OUT_NONINV = 2'd2,
      OUT_INV    = 2'd3
   } out_mode_e;

   localparam logic [2:0] WAVE_FULL = 3'd3;
   localparam logic [2:0] WAVE_VAR  = 3'd7;

   // log2 of the divide factor for each select code
   function automatic int unsigned div_shift(input logic [2:0] sel);
      case (sel)
         3'd1:    div_shift = 0;
         3'd2:    div_shift = 3;
         3'd3:    div_shift = 5;
         3'd4:    div_shift = 6;
         3'd5:    div_shift = 7;
         3'd6:    div_shift = 8;
         3'd7:    div_shift = 10;
         default: div_shift = 0;
      endcase
   endfunction

endpackage

// File: rtl/pcpwm_prescaler.sv
module pcpwm_prescaler #(
   parameter int PSC_BITS = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] sel,
   output logic       tick
);
   import pcpwm_pkg::*;

   logic [PSC_BITS-1:0] div_q;
   logic [PSC_BITS-1:0] mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) div_q <= '0;
      else        div_q <= div_q + 1'b1;
   end

   always_comb begin
      mask = '0;
      for (int i = 0; i < PSC_BITS; i++)
         if (i < int'(div_shift(sel))) mask[i] = 1'b1;
   end

   assign tick = (sel != 3'd0) && ((div_q & mask) == '0);

endmodule

// File: rtl/pcpwm_cmpbuf.sv
module pcpwm_cmpbuf #(
   parameter int W        = 8,
   parameter bit BUFFERED = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] a_wdata,
   input  logic         a_we,
   input  logic [W-1:0] b_wdata,
   input  logic         b_we,
   input  logic         load,
   output logic [W-1:0] a_act,
   output logic [W-1:0] b_act,
   output logic [W-1:0] b_next
);
   generate
      if (BUFFERED) begin : g_dbl
         logic [W-1:0] a_hold, b_hold, a_q, b_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               a_hold <= '0;
               b_hold <= '0;
               a_q    <= '0;
               b_q    <= '0;
            end else begin
               if (a_we) a_hold <= a_wdata;
               if (b_we) b_hold <= b_wdata;
               if (load) begin
                  a_q <= a_hold;
                  b_q <= b_hold;
               end
            end
         end
         assign a_act  = a_q;
         assign b_act  = b_q;
         assign b_next = b_hold;
      end else begin : g_direct
         logic [W-1:0] a_q, b_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               a_q <= '0;
               b_q <= '0;
            end else begin
               if (a_we) a_q <= a_wdata;
               if (b_we) b_q <= b_wdata;
            end
         end
         assign a_act  = a_q;
         assign b_act  = b_q;
         assign b_next = b_q;
      end
   endgenerate

endmodule

// File: rtl/pcpwm_counter.sv
module pcpwm_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic [2:0]   wave_mode,
   input  logic [W-1:0] var_top,
   output logic [W-1:0] cnt,
   output logic [W-1:0] top,
   output logic         up,
   output logic         step,
   output logic         turn,
   output logic         bottom
);
   import pcpwm_pkg::*;

   localparam logic [W-1:0] MAXV = {W{1'b1}};

   logic [W-1:0] cnt_q;
   logic         up_q;
   logic         run;

   assign run    = (wave_mode == WAVE_FULL) || (wave_mode == WAVE_VAR);
   assign top    = (wave_mode == WAVE_VAR) ? var_top : MAXV;
   assign step   = tick && run;
   assign turn   = step && up_q && (cnt_q >= top);
   assign bottom = step && !up_q && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         up_q  <= 1'b1;
      end else if (step) begin
         if (up_q) begin
            if (cnt_q >= top) begin
               if (cnt_q != '0) begin
                  cnt_q <= cnt_q - 1'b1;
                  up_q  <= 1'b0;
               end
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end else if (cnt_q == '0) begin
            cnt_q <= {{(W-1){1'b0}}, 1'b1};
            up_q  <= 1'b1;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign cnt = cnt_q;
   assign up  = up_q;

endmodule

// File: rtl/pcpwm_outgen.sv
module pcpwm_outgen #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic         up,
   input  logic         turn,
   input  logic         bottom,
   input  logic [W-1:0] cnt,
   input  logic [W-1:0] top,
   input  logic [W-1:0] cmp,
   input  logic [W-1:0] cmp_next,
   input  logic [1:0]   com_mode,
   output logic         oc
);
   import pcpwm_pkg::*;

   logic up_lvl, dn_lvl, active, oc_q;

   assign active = (com_mode == OUT_NONINV) || (com_mode == OUT_INV);
   assign up_lvl = (com_mode == OUT_INV);
   assign dn_lvl = ~up_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oc_q <= 1'b0;
      end else if (step && active) begin
         if (turn)
            oc_q <= ((cmp_next != '0) && (cmp_next >= top)) ? dn_lvl : up_lvl;
         else if (bottom)
            oc_q <= (cmp == '0) ? up_lvl : dn_lvl;
         else if (cnt == cmp)
            oc_q <= up ? up_lvl : dn_lvl;
      end
   end

   assign oc = oc_q;

endmodule

// File: rtl/pcpwm_timer.sv
module pcpwm_timer #(
   parameter int W        = 8,
   parameter int PSC_BITS = 10,
   parameter bit BUFFERED = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [2:0]   clk_sel,
   input  logic [2:0]   wave_mode,
   input  logic [1:0]   com_mode,
   input  logic         dir_en,
   input  logic [W-1:0] cmpa_wdata,
   input  logic         cmpa_we,
   input  logic [W-1:0] cmpb_wdata,
   input  logic         cmpb_we,
   input  logic         ovf_clr,
   output logic [W-1:0] count_o,
   output logic         oc_pin,
   output logic         oc_oe,
   output logic         ovf_flag
);
   generate
      if (W < 2) begin : g_bad_w
         $error("pcpwm_timer: W must be at least 2");
      end
      if (PSC_BITS < 10) begin : g_bad_psc
         $error("pcpwm_timer: PSC_BITS must be at least 10");
      end
   endgenerate

   logic         tick, step, turn, bottom, up, oc;
   logic [W-1:0] a_act, b_act, b_next, top;
   logic         ovf_q;

   pcpwm_prescaler #(.PSC_BITS(PSC_BITS)) u_psc (
      .clk(clk), .rst_n(rst_n), .sel(clk_sel), .tick(tick)
   );

   pcpwm_cmpbuf #(.W(W), .BUFFERED(BUFFERED)) u_buf (
      .clk(clk), .rst_n(rst_n),
      .a_wdata(cmpa_wdata), .a_we(cmpa_we),
      .b_wdata(cmpb_wdata), .b_we(cmpb_we),
      .load(turn), .a_act(a_act), .b_act(b_act), .b_next(b_next)
   );

   pcpwm_counter #(.W(W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wave_mode(wave_mode),
      .var_top(a_act), .cnt(count_o), .top(top), .up(up),
      .step(step), .turn(turn), .bottom(bottom)
   );

   pcpwm_outgen #(.W(W)) u_out (
      .clk(clk), .rst_n(rst_n), .step(step), .up(up), .turn(turn),
      .bottom(bottom), .cnt(count_o), .top(top), .cmp(b_act),
      .cmp_next(b_next), .com_mode(com_mode), .oc(oc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovf_q <= 1'b0;
      else if (bottom)  ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
   end

   assign ovf_flag = ovf_q;
   assign oc_oe    = dir_en && com_mode[1];
   assign oc_pin   = oc_oe ? oc : 1'b0;

endmodule

// File: rtl/pcpwm_timer_chk.sv
module pcpwm_timer_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic [2:0]   clk_sel,
   input logic [2:0]   wave_mode,
   input logic [1:0]   com_mode,
   input logic         dir_en,
   input logic         ovf_clr,
   input logic [W-1:0] count_o,
   input logic         oc_pin,
   input logic         ovf_flag
);
   p_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_sel == 3'd0) |=> $stable(count_o));

   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (count_o == $past(count_o)) || (count_o == $past(count_o) + 1'b1) ||
      (count_o == $past(count_o) - 1'b1));

   p_hold_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((wave_mode != 3'd3) && (wave_mode != 3'd7)) |=> $stable(count_o));

   p_pin_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!dir_en || !com_mode[1]) |-> !oc_pin);

   p_ovf_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> ($past(count_o) == '0) && (count_o == 1));

   p_ovf_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !ovf_clr) |=> ovf_flag);

endmodule

bind pcpwm_timer pcpwm_timer_chk #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .wave_mode(wave_mode),
   .com_mode(com_mode), .dir_en(dir_en), .ovf_clr(ovf_clr),
   .count_o(count_o), .oc_pin(oc_pin), .ovf_flag(ovf_flag)
);

// File: tb/tb_pcpwm_timer.sv
module tb_pcpwm_timer;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [2:0]   clk_sel = 3'd0;
   logic [2:0]   wave_mode = 3'd3;
   logic [1:0]   com_mode = 2'd2;
   logic         dir_en = 1'b1;
   logic [W-1:0] cmpa_wdata = '0;
   logic         cmpa_we = 1'b0;
   logic [W-1:0] cmpb_wdata = '0;
   logic         cmpb_we = 1'b0;
   logic         ovf_clr = 1'b0;
   logic [W-1:0] count_o;
   logic         oc_pin, oc_oe, ovf_flag;

   int vectors = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pcpwm_timer dut (
      .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .wave_mode(wave_mode),
      .com_mode(com_mode), .dir_en(dir_en), .cmpa_wdata(cmpa_wdata),
      .cmpa_we(cmpa_we), .cmpb_wdata(cmpb_wdata), .cmpb_we(cmpb_we),
      .ovf_clr(ovf_clr), .count_o(count_o), .oc_pin(oc_pin),
      .oc_oe(oc_oe), .ovf_flag(ovf_flag)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // ---------------- reference model (scoreboard producer) ----------------
   typedef struct packed { logic [W-1:0] c; logic oc; logic ov; } exp_t;
   exp_t q[$];

   logic [9:0]   m_div;
   logic [W-1:0] m_cnt, m_ha, m_hb, m_aa, m_ab;
   logic         m_up, m_oc, m_ov;

   always @(posedge clk) begin : model
      int sh;
      logic tk, run, stp, trn, bot, ul, dl;
      logic [W-1:0] top;
      if (!rst_n) begin
         m_div = '0; m_cnt = '0; m_up = 1'b1; m_oc = 1'b0; m_ov = 1'b0;
         m_ha = '0; m_hb = '0; m_aa = '0; m_ab = '0;
         q.delete();
      end else begin
         case (clk_sel)
            3'd2: sh = 3; 3'd3: sh = 5; 3'd4: sh = 6;
            3'd5: sh = 7; 3'd6: sh = 8; 3'd7: sh = 10;
            default: sh = 0;
         endcase
         tk  = (clk_sel != 0) && ((int'(m_div) % (1 << sh)) == 0);
         run = (wave_mode == 3'd3) || (wave_mode == 3'd7);
         top = (wave_mode == 3'd7) ? m_aa : 8'd255;
         stp = tk && run;
         trn = stp && m_up && (m_cnt >= top);
         bot = stp && !m_up && (m_cnt == 0);
         ul  = (com_mode == 2'd3);
         dl  = !ul;
         if (stp && com_mode[1]) begin
            if (trn)      m_oc = (m_hb != 0 && m_hb >= top) ? dl : ul;
            else if (bot) m_oc = (m_ab == 0) ? ul : dl;
            else if (m_cnt == m_ab) m_oc = m_up ? ul : dl;
         end
         if (bot) m_ov = 1'b1;
         else if (ovf_clr) m_ov = 1'b0;
         if (stp) begin
            if (m_up) begin
               if (m_cnt >= top) begin
                  if (m_cnt != 0) begin m_cnt = m_cnt - 1; m_up = 1'b0; end
               end else m_cnt = m_cnt + 1;
            end else if (m_cnt == 0) begin
               m_cnt = 1; m_up = 1'b1;
            end else m_cnt = m_cnt - 1;
         end
         if (trn) begin m_aa = m_ha; m_ab = m_hb; end
         if (cmpa_we) m_ha = cmpa_wdata;
         if (cmpb_we) m_hb = cmpb_wdata;
         m_div = m_div + 1'b1;
         q.push_back('{c: m_cnt, oc: m_oc, ov: m_ov});
      end
   end

   // ---------------- monitor (scoreboard consumer) ----------------
   always @(negedge clk) begin
      if (rst_n && q.size() > 0) begin
         exp_t e;
         logic oe_e, pin_e;
         e = q.pop_front();
         oe_e  = dir_en && com_mode[1];
         pin_e = oe_e ? e.oc : 1'b0;
         chk(count_o == e.c, "R3 count", int'(count_o), int'(e.c));
         chk(oc_pin == pin_e, "R5 pin", int'(oc_pin), int'(pin_e));
         chk(oc_oe == oe_e, "R10 oe", int'(oc_oe), int'(oe_e));
         chk(ovf_flag == e.ov, "R11 ovf", int'(ovf_flag), int'(e.ov));
      end
   end

   // ---------------- driver helpers ----------------
   task automatic smp(); @(negedge clk); endtask

   task automatic wr_a(input logic [W-1:0] v);
      smp(); #1 cmpa_wdata = v; cmpa_we = 1'b1;
      smp(); #1 cmpa_we = 1'b0;
   endtask

   task automatic wr_b(input logic [W-1:0] v);
      smp(); #1 cmpb_wdata = v; cmpb_we = 1'b1;
      smp(); #1 cmpb_we = 1'b0;
   endtask

   task automatic wait_cnt(input logic [W-1:0] v);
      do smp(); while (count_o != v);
   endtask

   // sample one period from a zero of the counter; returns length and high count
   task automatic period(output int len, output int hi);
      wait_cnt(0);
      len = 0; hi = 0;
      do begin
         len++;
         if (oc_pin) hi++;
         smp();
      end while (count_o != 0);
   endtask

   task automatic count_moves(input int cycles, output int moves);
      logic [W-1:0] prev;
      moves = 0;
      smp(); prev = count_o;
      for (int i = 0; i < cycles; i++) begin
         smp();
         if (count_o != prev) moves++;
         prev = count_o;
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin : main
      int len, hi, mv, mx;
      // R1: reset state
      repeat (3) smp();
      chk(count_o == 0, "R1 count", int'(count_o), 0);
      chk(ovf_flag == 0, "R1 ovf", int'(ovf_flag), 0);
      chk(oc_pin == 0, "R1 pin", int'(oc_pin), 0);
      #1 rst_n = 1'b1;

      // R2: select 0 stops the counter
      count_moves(20, mv);
      chk(mv == 0, "R2 stopped", mv, 0);

      // R5/R7/R3: non-inverted, compare 100, full-scale ceiling, N=1
      wr_b(8'd100);
      smp(); #1 clk_sel = 3'd1;
      wait_cnt(255);
      period(len, hi);
      chk(len == 510, "R3 period", len, 510);
      chk(hi == 200, "R5 duty", hi, 200);

      // R6: inverted
      smp(); #1 com_mode = 2'd3;
      wait_cnt(255);
      period(len, hi);
      chk(hi == 310, "R6 inverted duty", hi, 310);

      // R7: extremes
      smp(); #1 com_mode = 2'd2;
      wr_b(8'd0);
      wait_cnt(255);
      period(len, hi);
      chk(hi == 0, "R7 compare zero", hi, 0);
      wr_b(8'd255);
      wait_cnt(255);
      period(len, hi);
      chk(hi == 510, "R7 compare max", hi, 510);

      // R9 / R8: pending value waits for the ceiling, forced level there
      wait_cnt(255); wait_cnt(0); wait_cnt(10);
      wr_b(8'd50);
      wait_cnt(254);
      chk(oc_pin == 1'b1, "R9 not yet loaded", int'(oc_pin), 1);
      wait_cnt(255);
      chk(oc_pin == 1'b1, "R9 at ceiling", int'(oc_pin), 1);
      smp();
      chk(count_o == 254, "R8 turned", int'(count_o), 254);
      chk(oc_pin == 1'b0, "R8 forced level", int'(oc_pin), 0);

      // R2: divide by 8
      smp(); #1 clk_sel = 3'd2;
      count_moves(800, mv);
      chk(mv == 100, "R2 divide 8", mv, 100);

      // R4: ceiling from compare A
      smp(); #1 clk_sel = 3'd1;
      wr_a(8'd20);
      smp(); #1 wave_mode = 3'd7;
      repeat (600) smp();
      mx = 0;
      for (int i = 0; i < 100; i++) begin
         smp();
         if (int'(count_o) > mx) mx = int'(count_o);
      end
      chk(mx == 20, "R4 variable ceiling", mx, 20);
      period(len, hi);
      chk(len == 40, "R4 period", len, 40);
      smp(); #1 wave_mode = 3'd5;
      count_moves(20, mv);
      chk(mv == 0, "R4 other mode holds", mv, 0);

      // R2: divide by 1024 with a ceiling of 2
      wr_a(8'd2);
      smp(); #1 wave_mode = 3'd7;
      repeat (100) smp();
      smp(); #1 clk_sel = 3'd7;
      count_moves(4096, mv);
      chk(mv == 4, "R2 divide 1024", mv, 4);

      // R10: pin gating
      smp(); #1 dir_en = 1'b0;
      smp();
      chk(oc_oe == 0 && oc_pin == 0, "R10 dir off", int'(oc_oe), 0);
      #1 dir_en = 1'b1; com_mode = 2'd1;
      smp();
      chk(oc_oe == 0 && oc_pin == 0, "R10 mode off", int'(oc_oe), 0);
      #1 com_mode = 2'd2;

      // R11: sticky flag and clear
      smp(); #1 clk_sel = 3'd0;
      smp();
      chk(ovf_flag == 1, "R11 flag set", int'(ovf_flag), 1);
      #1 ovf_clr = 1'b1;
      smp(); #1 ovf_clr = 1'b0;
      smp();
      chk(ovf_flag == 0, "R11 cleared", int'(ovf_flag), 0);
      #1 clk_sel = 3'd1;
      repeat (20) smp();
      chk(ovf_flag == 1, "R11 sets again", int'(ovf_flag), 1);

      repeat (4) smp();
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule